// File: doc/BRIEF.md
# Latching Input Change Monitor with Deferred Interrupt

This block watches a bank of asynchronous input pins and reports every change, even a short pulse that returns to its old level, until software reads it out. Each pin passes through a synchronizer. The synchronized value is then compared with a held snapshot, and any difference sets a sticky flag for that bit. An enable mask selects which flagged bits pull the active-low interrupt output.

A serial-bus slave controller sits next to the block and drives its control inputs. That controller pulses a sample strobe on the address acknowledge of each transaction, and again before each new byte pair of a long read. The strobe reloads the snapshot, clears the live flags and releases the interrupt. It also keeps a copy of the flags as they stood just before the clear, so the controller can transmit them. While a read or write transaction is open, the interrupt is not reasserted. A new enabled change is held back until the STOP event. If a later resample has already captured that change before STOP, no interrupt is raised at all. A write transaction loads the mask.

Top module: `port_change_monitor`

## Requirements
- R1: A level change on `port_in` shows in `flag_live` exactly SYNC_STAGES+1 rising edges after it is applied, and not earlier.
- R2: A flag bit, once set, stays set when the input returns to its old level and stays set until the next sample strobe. Flags are set whether or not the matching mask bit is set.
- R3: One edge after `sample_stb`, `snap_q` holds the synchronized inputs, `flag_live` is zero and `irq_n` is 1. `flag_prev` holds the flags that were set before that strobe.
- R4: After reset, `irq_n` is 1 and both flag outputs are zero. Input levels present during and after reset set no flag, and the snapshot settles to them.
- R5: The mask resets to all ones. A flagged bit whose mask bit is 0 never pulls `irq_n` low.
- R6: With no transaction open, `irq_n` goes low one edge after a flag bit that is also mask-enabled is set. It stays low until a sample strobe.
- R7: While `rd_busy` or `wr_busy` is high and `stop_evt` is low, `irq_n` does not fall. An enabled change that occurs during the transaction pulls `irq_n` low on the edge that sees `stop_evt`.
- R8: If a resample strobe clears the changed flag before STOP, `irq_n` stays high at and after STOP.
- R9: At STOP, the interrupt decision uses the mask as written during that transaction.
- R10: The mask changes only on a cycle with `mask_we` high. A level on `mask_din` without `mask_we` is ignored. Only `rst` returns the mask to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| port_in | input | W | Asynchronous input pins |
| sample_stb | input | 1 | One-cycle strobe: snapshot load, flag clear, interrupt release |
| rd_busy | input | 1 | A read transaction is open |
| wr_busy | input | 1 | A write transaction is open |
| stop_evt | input | 1 | One-cycle STOP event that closes the transaction |
| mask_we | input | 1 | Load `mask_din` into the mask |
| mask_din | input | W | New mask value |
| snap_q | output | W | Snapshot, i.e. the port value to transmit |
| flag_live | output | W | Current sticky change flags |
| flag_prev | output | W | Flags as they stood before the last strobe |
| irq_n | output | 1 | Registered active-low interrupt (open-drain enable) |

## Verification
A pin change reaches `flag_live` after SYNC_STAGES+1 rising edges and `irq_n` one edge later. The bench drives each change just after a falling edge and then waits exactly that many falling edges before it samples. It also samples one edge before the due time, to confirm the flag is not there early. The effects of a strobe, a mask write and STOP are all checked at the first falling edge after the rising edge that registers them. In deferral scenarios, `irq_n` is sampled many cycles after the change and before STOP, so that a missing hold shows up as an early fall.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  // Transaction controls coming from the serial slave
  typedef struct packed {
    logic sample;  // snapshot + flag clear strobe
    logic busy;    // read or write transaction open
    logic stop;    // transaction closing event
  } pcm_bus_t;

  function automatic int arm_cycles(input int stages);
    return stages + 1;
  endfunction
endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= din;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/pcm_track.sv
module pcm_track
  import pcm_pkg::*;
#(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] port_s,
  input  logic         sample,
  output logic [W-1:0] snap_q,
  output logic [W-1:0] flag_q,
  output logic [W-1:0] prev_q
);
  // The snapshot follows the synchronizer until its pipe holds real pin data
  localparam int ARM_CYC = arm_cycles(STAGES);
  localparam int CW      = $clog2(ARM_CYC + 1);

  logic [CW-1:0] arm_cnt;
  logic          armed;
  logic [W-1:0]  diff;

  assign armed = (arm_cnt == CW'(ARM_CYC));
  assign diff  = armed ? (port_s ^ snap_q) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_cnt <= '0;
      snap_q  <= '0;
      flag_q  <= '0;
      prev_q  <= '0;
    end else begin
      if (!armed) arm_cnt <= arm_cnt + 1'b1;
      if (sample) begin
        snap_q <= port_s;
        prev_q <= flag_q | diff;
        flag_q <= '0;
      end else if (!armed) begin
        snap_q <= port_s;
        flag_q <= '0;
      end else begin
        flag_q <= flag_q | diff;
      end
    end
  end
endmodule

// File: rtl/pcm_irq.sv
module pcm_irq
  import pcm_pkg::*;
#(
  parameter int             W         = 8,
  parameter logic [W-1:0]   MASK_INIT = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  pcm_bus_t     bus,
  input  logic [W-1:0] flags,
  input  logic         mask_we,
  input  logic [W-1:0] mask_din,
  output logic [W-1:0] mask_q,
  output logic         irq_n
);
  logic hit;
  logic hold;

  assign hit  = |(flags & mask_q);
  assign hold = bus.busy & ~bus.stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= MASK_INIT;
      irq_n  <= 1'b1;
    end else begin
      if (mask_we) mask_q <= mask_din;
      if (bus.sample)  irq_n <= 1'b1;
      else if (!hold)  irq_n <= ~hit;
    end
  end
endmodule

// File: rtl/port_change_monitor.sv
module port_change_monitor
  import pcm_pkg::*;
#(
  parameter int           W           = 8,
  parameter int           SYNC_STAGES = 2,
  parameter logic [W-1:0] MASK_INIT   = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] port_in,
  input  logic         sample_stb,
  input  logic         rd_busy,
  input  logic         wr_busy,
  input  logic         stop_evt,
  input  logic         mask_we,
  input  logic [W-1:0] mask_din,
  output logic [W-1:0] snap_q,
  output logic [W-1:0] flag_live,
  output logic [W-1:0] flag_prev,
  output logic         irq_n
);
  logic [W-1:0] port_s;
  logic [W-1:0] mask_q;
  pcm_bus_t     bus;

  assign bus.sample = sample_stb;
  assign bus.busy   = rd_busy | wr_busy;
  assign bus.stop   = stop_evt;

  pcm_sync #(.W(W), .STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (port_in),
    .dout (port_s)
  );

  pcm_track #(.W(W), .STAGES(SYNC_STAGES)) i_track (
    .clk    (clk),
    .rst    (rst),
    .port_s (port_s),
    .sample (sample_stb),
    .snap_q (snap_q),
    .flag_q (flag_live),
    .prev_q (flag_prev)
  );

  pcm_irq #(.W(W), .MASK_INIT(MASK_INIT)) i_irq (
    .clk      (clk),
    .rst      (rst),
    .bus      (bus),
    .flags    (flag_live),
    .mask_we  (mask_we),
    .mask_din (mask_din),
    .mask_q   (mask_q),
    .irq_n    (irq_n)
  );
endmodule

// File: rtl/pcm_checker.sv
module pcm_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         sample_stb,
  input logic         rd_busy,
  input logic         wr_busy,
  input logic         stop_evt,
  input logic         mask_we,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] snap_q,
  input logic [W-1:0] flag_live,
  input logic         irq_n
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (irq_n && flag_live == '0 && mask_q == '1)); // R4

  AST_STROBE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> (irq_n && flag_live == '0)); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    !sample_stb |=> ((flag_live & $past(flag_live)) == $past(flag_live))); // R2

  AST_SNAP_HELD: assert property (@(posedge clk) disable iff (rst)
    (!sample_stb && $past(!rst) && $past(!rst, 2) && $past(!rst, 3) && $past(!rst, 4))
      |=> $stable(snap_q)); // R3

  AST_NO_IRQ_IN_TXN: assert property (@(posedge clk) disable iff (rst)
    ((rd_busy || wr_busy) && !stop_evt && irq_n) |=> irq_n); // R7

  AST_IRQ_NEEDS_ENABLED_FLAG: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> $past(|(flag_live & mask_q))); // R5

  AST_MASK_ONLY_ON_WE: assert property (@(posedge clk) disable iff (rst)
    !mask_we |=> $stable(mask_q)); // R10
endmodule

bind port_change_monitor pcm_checker #(.W(W)) i_pcm_checker (
  .clk        (clk),
  .rst        (rst),
  .sample_stb (sample_stb),
  .rd_busy    (rd_busy),
  .wr_busy    (wr_busy),
  .stop_evt   (stop_evt),
  .mask_we    (mask_we),
  .mask_q     (i_irq.mask_q),
  .snap_q     (snap_q),
  .flag_live  (flag_live),
  .irq_n      (irq_n)
);

// File: tb/test_port_change_monitor.sv
module test_port_change_monitor;
  localparam int W    = 8;
  localparam int SYNC = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] port_in = '0;
  logic         sample_stb = 1'b0;
  logic         rd_busy = 1'b0;
  logic         wr_busy = 1'b0;
  logic         stop_evt = 1'b0;
  logic         mask_we = 1'b0;
  logic [W-1:0] mask_din = '0;
  logic [W-1:0] snap_q;
  logic [W-1:0] flag_live;
  logic [W-1:0] flag_prev;
  logic         irq_n;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  port_change_monitor #(.W(W), .SYNC_STAGES(SYNC)) i_port_change_monitor (
    .clk(clk), .rst(rst), .port_in(port_in), .sample_stb(sample_stb),
    .rd_busy(rd_busy), .wr_busy(wr_busy), .stop_evt(stop_evt),
    .mask_we(mask_we), .mask_din(mask_din), .snap_q(snap_q),
    .flag_live(flag_live), .flag_prev(flag_prev), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [W-1:0] pins);
    @(negedge clk);
    rst = 1'b1; port_in = pins;
    sample_stb = 0; rd_busy = 0; wr_busy = 0; stop_evt = 0; mask_we = 0;
    cyc(2);
    rst = 1'b0;
    cyc(8);
  endtask

  task automatic strobe;
    sample_stb = 1'b1;
    cyc(1);
    sample_stb = 1'b0;
  endtask

  task automatic stop;
    stop_evt = 1'b1; rd_busy = 1'b0; wr_busy = 1'b0;
    cyc(1);
    stop_evt = 1'b0;
  endtask

  task automatic write_mask(input logic [W-1:0] m);
    wr_busy = 1'b1;
    strobe();
    mask_we = 1'b1; mask_din = m;
    cyc(1);
    mask_we = 1'b0;
    cyc(1);
    stop();
  endtask

  task automatic t_reset_state;
    do_reset(8'hA5);
    check("R4 irq_n after reset", irq_n, 1);
    check("R4 no flag from reset levels", flag_live, 0);
    check("R4 flag_prev after reset", flag_prev, 0);
    check("R4 snapshot settled", snap_q, 8'hA5);
    do_reset(8'h00);
    check("R4 snapshot zero", snap_q, 0);
  endtask

  task automatic t_detect;
    port_in = 8'h01;
    cyc(SYNC);
    check("R1 flag not early", flag_live, 0);
    cyc(1);
    check("R1 flag on time", flag_live, 8'h01);
    check("R6 irq not yet", irq_n, 1);
    cyc(1);
    check("R6 irq asserted idle", irq_n, 0);
    port_in = 8'h00;
    cyc(6);
    check("R2 flag sticky after return", flag_live, 8'h01);
    check("R6 irq held until strobe", irq_n, 0);
  endtask

  task automatic t_sample;
    strobe();
    check("R3 snapshot loaded", snap_q, 8'h00);
    check("R3 flags cleared", flag_live, 0);
    check("R3 previous flags kept", flag_prev, 8'h01);
    check("R3 irq released", irq_n, 1);
    port_in = 8'h0C;
    cyc(SYNC + 1);
    strobe();
    check("R3 snapshot new", snap_q, 8'h0C);
    check("R3 previous flags new", flag_prev, 8'h0C);
    check("R3 irq released at strobe", irq_n, 1);
    cyc(4);
    check("R3 irq stays high", irq_n, 1);
  endtask

  task automatic t_mask;
    write_mask(8'h0F);
    check("R5 irq high after write", irq_n, 1);
    port_in = 8'h4C;
    cyc(8);
    check("R2 flag set despite mask", flag_live, 8'h40);
    check("R5 masked bit no irq", irq_n, 1);
    port_in = 8'h4E;
    cyc(SYNC + 2);
    check("R5 enabled bit irq", irq_n, 0);
    write_mask(8'hFF);
  endtask

  task automatic t_read_defer;
    rd_busy = 1'b1;
    strobe();
    check("R7 irq released at address", irq_n, 1);
    port_in = port_in ^ 8'h80;
    cyc(10);
    check("R7 flag seen in read", flag_live, 8'h80);
    check("R7 irq held in read", irq_n, 1);
    stop();
    check("R7 irq at STOP after read", irq_n, 0);
  endtask

  task automatic t_cancel;
    rd_busy = 1'b1;
    strobe();
    port_in = port_in ^ 8'h01;
    cyc(5);
    strobe();
    check("R3 resample reports flag", flag_prev, 8'h01);
    cyc(2);
    stop();
    check("R8 irq cancelled at STOP", irq_n, 1);
    cyc(3);
    check("R8 irq stays high", irq_n, 1);
  endtask

  task automatic t_write_defer;
    wr_busy = 1'b1;
    strobe();
    port_in = port_in ^ 8'h04;
    cyc(6);
    check("R7 irq held in write", irq_n, 1);
    stop();
    check("R7 irq at STOP after write", irq_n, 0);
  endtask

  task automatic t_mask_at_stop;
    wr_busy = 1'b1;
    strobe();
    mask_we = 1'b1; mask_din = 8'h00;
    cyc(1);
    mask_we = 1'b0;
    port_in = port_in ^ 8'h20;
    cyc(6);
    stop();
    check("R9 zero mask at STOP", irq_n, 1);
    check("R9 flag still recorded", flag_live, 8'h20);
    wr_busy = 1'b1;
    strobe();
    mask_we = 1'b1; mask_din = 8'h20;
    cyc(1);
    mask_we = 1'b0;
    port_in = port_in ^ 8'h20;
    cyc(6);
    stop();
    check("R9 new mask at STOP", irq_n, 0);
  endtask

  task automatic t_mask_keep;
    wr_busy = 1'b1;
    strobe();
    mask_din = 8'hFF;
    cyc(2);
    port_in = port_in ^ 8'h01;
    cyc(6);
    stop();
    check("R10 mask_din ignored without we", irq_n, 1);
    do_reset(port_in);
    port_in = port_in ^ 8'h40;
    cyc(SYNC + 2);
    check("R10 reset restores full mask", irq_n, 0);
  endtask

  bit done = 0;

  initial begin
    t_reset_state();
    t_detect();
    t_sample();
    t_mask();
    t_read_defer();
    t_cancel();
    t_write_defer();
    t_mask_at_stop();
    t_mask_keep();
    done = 1;
  end

  initial begin
    int waited = 0;
    while (!done && waited < 200000) begin
      @(posedge clk);
      waited++;
    end
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule